// File: doc/BRIEF.md
# Tiled Two-Dimensional Burst Address Generator

This block accepts one rectangular access command for a frame buffer and expands it into a stream of DRAM burst requests. The command gives a start byte address, a width in bytes, a height in rows and the line pitch as a power of two. The block walks the rectangle one image row at a time, left to right. For every burst it computes the channel, bank, row, column and byte length. The result leaves on a valid/ready request port, and a one-cycle done pulse follows the last burst.

Two address windows are tiled, and each has its own tile shape. Window A uses tiles 16 bytes wide and 16 lines tall. Window B uses tiles 32 bytes wide and 8 lines tall. Either shape fills one 256-byte DRAM page, and horizontally neighbouring tiles fall on successive banks. Addresses outside both windows use a plain linear row/bank/column split. The window is chosen once, from the start address, and holds for the whole command. A burst is cut short at the maximum length, at a tile-row edge and at a 64-byte channel edge.

The controller has four states. IDLE waits for a command. On accept it moves to CALC, or straight to DONE when the width or the height is zero. CALC registers the next burst and moves to SEND. SEND holds the request until it is taken. It then moves to CALC while bytes remain, or to DONE after the final burst. DONE raises the done pulse and moves back to IDLE.

Top module: `tile2d_burst_gen`

## Requirements
- R1: `cmd_ready` is high only in IDLE. A command is captured on the clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: Bursts cover the rows in order, starting with the top row. Within a row they run left to right, and their lengths add up to the command width. Row r starts at the start address plus r times 2^`cmd_stride_lg`.
- R3: Window A covers addresses 0x0010_0000 to 0x001F_FFFF. Let x and y be the window offset modulo the pitch P and divided by P. Then col = (y%16)*16 + x%16, bank = (x/16)%4, row = 0x400 + (y/16)*(P/64) + x/64, and chan = (x/64)%2.
- R4: Window B covers addresses 0x0020_0000 to 0x002F_FFFF. Then col = (y%8)*32 + x%32, bank = (x/32)%4, row = 0x800 + (y/8)*(P/128) + x/128, and chan = (x/64)%2.
- R5: For any other address A, col = A%256, bank = (A/256)%4, row = A/1024 and chan = (A/64)%2.
- R6: Every burst is 1 to 32 bytes long. In a tiled window, no burst crosses a tile edge: x%TW + len is at most TW, where TW is the tile width.
- R7: No burst crosses a 64-byte channel edge. The edge is measured on x inside a tiled window and on the address otherwise.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and every request field stays unchanged.
- R9: `done` is high for exactly one cycle, the cycle after the last burst is taken. If the width or the height is zero, no burst is issued and `done` is high in the cycle after the command is accepted.
- R10: After reset, `cmd_ready` is 1 and both `req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, able to take a command |
| cmd_addr | input | 32 | Start byte address of the rectangle |
| cmd_width | input | 12 | Rectangle width in bytes |
| cmd_height | input | 11 | Rectangle height in rows |
| cmd_stride_lg | input | 4 | log2 of the line pitch in bytes (7 to 15) |
| req_valid | output | 1 | Burst request offered |
| req_ready | input | 1 | Burst request taken |
| req_chan | output | 1 | Channel |
| req_bank | output | 2 | Bank |
| req_row | output | 22 | DRAM row |
| req_col | output | 8 | Byte column within the page |
| req_len | output | 6 | Burst length in bytes |
| done | output | 1 | One-cycle pulse after the last burst |

## Verification
If a command is accepted in cycle k, its first burst is valid in cycle k+2. Each later burst is valid two cycles after the previous one is taken, and `done` is due one cycle after the final handshake. A zero-sized command gives `done` in cycle k+1. The bench drives its inputs one time unit after the rising edge and samples at the falling edge. It compares each handshake against a queue built in advance from the mapping formulas. It also records the cycle of the accept and of the last handshake, so that the `done` cycle can be checked exactly. Backpressure comes from a pseudo-random `req_ready`, and each stalled cycle is checked for frozen fields.

// File: rtl/tg_pkg.sv
package tg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CALC,
        ST_SEND,
        ST_DONE
    } tg_state_e;

    typedef enum logic [1:0] {
        MAP_LINEAR,
        MAP_TILE_A,
        MAP_TILE_B
    } tg_map_e;
endpackage

// File: rtl/tg_region_sel.sv
module tg_region_sel
    import tg_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              REGION_LG = 20,
    parameter logic [31:0]     A_BASE    = 32'h0010_0000,
    parameter logic [31:0]     B_BASE    = 32'h0020_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output tg_map_e           map_sel
);
    localparam int TAG_W = ADDR_W - REGION_LG;

    logic [TAG_W-1:0] tag;
    assign tag = addr[ADDR_W-1:REGION_LG];

    always_comb begin
        if (tag == A_BASE[ADDR_W-1:REGION_LG])
            map_sel = MAP_TILE_A;
        else if (tag == B_BASE[ADDR_W-1:REGION_LG])
            map_sel = MAP_TILE_B;
        else
            map_sel = MAP_LINEAR;
    end
endmodule

// File: rtl/tg_tile_map.sv
module tg_tile_map #(
    parameter int          ADDR_W    = 32,
    parameter int          SLG_W     = 4,
    parameter int          REGION_LG = 20,
    parameter int          TW_LG     = 4,
    parameter int          TH_LG     = 4,
    parameter int          NB_LG     = 2,
    parameter int          CH_LG     = 6,
    parameter int          NCH_LG    = 1,
    parameter int          ROW_W     = 22,
    parameter int          EDGE_W    = 7,
    parameter logic [31:0] ROW_BASE  = 32'h400
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [SLG_W-1:0]       stride_lg,
    output logic [NCH_LG-1:0]      chan,
    output logic [NB_LG-1:0]       bank,
    output logic [ROW_W-1:0]       row,
    output logic [TW_LG+TH_LG-1:0] col,
    output logic [EDGE_W-1:0]      edge_room
);
    localparam int PAGE_LG = TW_LG + TH_LG;
    localparam logic [ADDR_W-1:0] ONE         = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] REGION_MASK = (ONE << REGION_LG) - ONE;
    localparam logic [ADDR_W-1:0] TW_MASK     = (ONE << TW_LG) - ONE;
    localparam logic [ADDR_W-1:0] TH_MASK     = (ONE << TH_LG) - ONE;
    localparam logic [ADDR_W-1:0] CH_MASK     = (ONE << CH_LG) - ONE;

    logic [ADDR_W-1:0] off, pitch_mask, xb, yl, tx, ty;
    logic [ADDR_W-1:0] row_full, col_full, tile_room, ch_room, room;
    logic [SLG_W-1:0]  shamt;

    always_comb begin
        off        = addr & REGION_MASK;
        pitch_mask = (ONE << stride_lg) - ONE;
        xb         = off & pitch_mask;
        yl         = off >> stride_lg;
        tx         = xb >> TW_LG;
        ty         = yl >> TH_LG;
        shamt      = stride_lg - SLG_W'(TW_LG + NB_LG);
        row_full   = ADDR_W'(ROW_BASE) + (ty << shamt) + (tx >> NB_LG);
        col_full   = ((yl & TH_MASK) << TW_LG) | (xb & TW_MASK);
        tile_room  = (ONE << TW_LG) - (xb & TW_MASK);
        ch_room    = (ONE << CH_LG) - (xb & CH_MASK);
        room       = (tile_room < ch_room) ? tile_room : ch_room;
    end

    assign chan      = xb[CH_LG +: NCH_LG];
    assign bank      = tx[NB_LG-1:0];
    assign row       = row_full[ROW_W-1:0];
    assign col       = col_full[PAGE_LG-1:0];
    assign edge_room = room[EDGE_W-1:0];
endmodule

// File: rtl/tg_lin_map.sv
module tg_lin_map #(
    parameter int ADDR_W  = 32,
    parameter int PAGE_LG = 8,
    parameter int NB_LG   = 2,
    parameter int CH_LG   = 6,
    parameter int NCH_LG  = 1,
    parameter int EDGE_W  = 7
) (
    input  logic [ADDR_W-1:0]               addr,
    output logic [NCH_LG-1:0]               chan,
    output logic [NB_LG-1:0]                bank,
    output logic [ADDR_W-PAGE_LG-NB_LG-1:0] row,
    output logic [PAGE_LG-1:0]              col,
    output logic [EDGE_W-1:0]               edge_room
);
    localparam logic [EDGE_W-1:0] CH_SPAN = EDGE_W'(1) << CH_LG;

    assign chan      = addr[CH_LG +: NCH_LG];
    assign bank      = addr[PAGE_LG +: NB_LG];
    assign row       = addr[ADDR_W-1:PAGE_LG+NB_LG];
    assign col       = addr[PAGE_LG-1:0];
    assign edge_room = CH_SPAN - EDGE_W'(addr[CH_LG-1:0]);
endmodule

// File: rtl/tile2d_burst_gen.sv
module tile2d_burst_gen
    import tg_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          W_W       = 12,
    parameter int          H_W       = 11,
    parameter int          SLG_W     = 4,
    parameter int          MAX_LEN   = 32,
    parameter int          NB_LG     = 2,
    parameter int          NCH_LG    = 1,
    parameter int          CH_LG     = 6,
    parameter int          REGION_LG = 20,
    parameter logic [31:0] A_BASE    = 32'h0010_0000,
    parameter logic [31:0] B_BASE    = 32'h0020_0000,
    parameter int          A_TW_LG   = 4,
    parameter int          A_TH_LG   = 4,
    parameter int          B_TW_LG   = 5,
    parameter int          B_TH_LG   = 3,
    localparam int         PAGE_LG   = A_TW_LG + A_TH_LG,
    localparam int         ROW_W     = ADDR_W - PAGE_LG - NB_LG,
    localparam int         LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [W_W-1:0]     cmd_width,
    input  logic [H_W-1:0]     cmd_height,
    input  logic [SLG_W-1:0]   cmd_stride_lg,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [NCH_LG-1:0]  req_chan,
    output logic [NB_LG-1:0]   req_bank,
    output logic [ROW_W-1:0]   req_row,
    output logic [PAGE_LG-1:0] req_col,
    output logic [LEN_W-1:0]   req_len,
    output logic               done
);
    localparam int EDGE_W = CH_LG + 1;
    localparam int NSCH   = 2;

    tg_state_e          state_q, state_d;
    tg_map_e            map_q, map_in;
    logic [SLG_W-1:0]   slg_q;
    logic [W_W-1:0]     width_q, rem_q, rem_after;
    logic [H_W-1:0]     rows_left_q;
    logic [ADDR_W-1:0]  line_q, cur_q, pitch;
    logic               accept, taken, row_end, last_row;

    // mapper results
    logic [NCH_LG-1:0]  t_chan [NSCH];
    logic [NB_LG-1:0]   t_bank [NSCH];
    logic [ROW_W-1:0]   t_row  [NSCH];
    logic [PAGE_LG-1:0] t_col  [NSCH];
    logic [EDGE_W-1:0]  t_room [NSCH];
    logic [NCH_LG-1:0]  l_chan, m_chan;
    logic [NB_LG-1:0]   l_bank, m_bank;
    logic [ROW_W-1:0]   l_row, m_row;
    logic [PAGE_LG-1:0] l_col, m_col;
    logic [EDGE_W-1:0]  l_room, m_room;
    logic [W_W:0]       lim;

    tg_region_sel #(
        .ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .A_BASE(A_BASE), .B_BASE(B_BASE)
    ) u_region (
        .addr(cmd_addr), .map_sel(map_in)
    );

    for (genvar g = 0; g < NSCH; g++) begin : g_scheme
        localparam int          TW_LG_G = (g == 0) ? A_TW_LG : B_TW_LG;
        localparam int          TH_LG_G = (g == 0) ? A_TH_LG : B_TH_LG;
        localparam logic [31:0] BASE_G  = (g == 0) ? A_BASE : B_BASE;
        tg_tile_map #(
            .ADDR_W(ADDR_W), .SLG_W(SLG_W), .REGION_LG(REGION_LG),
            .TW_LG(TW_LG_G), .TH_LG(TH_LG_G), .NB_LG(NB_LG), .CH_LG(CH_LG),
            .NCH_LG(NCH_LG), .ROW_W(ROW_W), .EDGE_W(EDGE_W),
            .ROW_BASE(BASE_G >> (PAGE_LG + NB_LG))
        ) u_tile (
            .addr(cur_q), .stride_lg(slg_q),
            .chan(t_chan[g]), .bank(t_bank[g]), .row(t_row[g]),
            .col(t_col[g]), .edge_room(t_room[g])
        );
    end

    tg_lin_map #(
        .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .NB_LG(NB_LG), .CH_LG(CH_LG),
        .NCH_LG(NCH_LG), .EDGE_W(EDGE_W)
    ) u_lin (
        .addr(cur_q), .chan(l_chan), .bank(l_bank), .row(l_row),
        .col(l_col), .edge_room(l_room)
    );

    always_comb begin
        unique case (map_q)
            MAP_TILE_A: begin
                m_chan = t_chan[0]; m_bank = t_bank[0]; m_row = t_row[0];
                m_col  = t_col[0];  m_room = t_room[0];
            end
            MAP_TILE_B: begin
                m_chan = t_chan[1]; m_bank = t_bank[1]; m_row = t_row[1];
                m_col  = t_col[1];  m_room = t_room[1];
            end
            default: begin
                m_chan = l_chan; m_bank = l_bank; m_row = l_row;
                m_col  = l_col;  m_room = l_room;
            end
        endcase
        lim = {1'b0, rem_q};
        if ((W_W+1)'(MAX_LEN) < lim) lim = (W_W+1)'(MAX_LEN);
        if ((W_W+1)'(m_room) < lim)  lim = (W_W+1)'(m_room);
    end

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign taken     = req_ready && (state_q == ST_SEND);
    assign rem_after = rem_q - W_W'(req_len);
    assign row_end   = (rem_after == '0);
    assign last_row  = (rows_left_q == H_W'(1));
    assign pitch     = ADDR_W'(1) << slg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)
                         state_d = ((cmd_width == '0) || (cmd_height == '0)) ? ST_DONE : ST_CALC;
            ST_CALC: state_d = ST_SEND;
            ST_SEND: if (taken)
                         state_d = (row_end && last_row) ? ST_DONE : ST_CALC;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        req_valid = (state_q == ST_SEND);
        done      = (state_q == ST_DONE);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= MAP_LINEAR; slg_q <= '0; width_q <= '0; rem_q <= '0;
            rows_left_q <= '0; line_q <= '0; cur_q <= '0;
            req_chan <= '0; req_bank <= '0; req_row <= '0; req_col <= '0; req_len <= '0;
        end else begin
            if (accept) begin
                map_q       <= map_in;
                slg_q       <= cmd_stride_lg;
                width_q     <= cmd_width;
                rem_q       <= cmd_width;
                rows_left_q <= cmd_height;
                line_q      <= cmd_addr;
                cur_q       <= cmd_addr;
            end
            if (state_q == ST_CALC) begin
                req_chan <= m_chan;
                req_bank <= m_bank;
                req_row  <= m_row;
                req_col  <= m_col;
                req_len  <= lim[LEN_W-1:0];
            end
            if (taken) begin
                if (row_end) begin
                    rows_left_q <= rows_left_q - H_W'(1);
                    line_q      <= line_q + pitch;
                    cur_q       <= line_q + pitch;
                    rem_q       <= width_q;
                end else begin
                    cur_q <= cur_q + ADDR_W'(req_len);
                    rem_q <= rem_after;
                end
            end
        end
    end

    // R6
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (req_len <= LEN_W'(MAX_LEN)));

    // R6
    tile_a_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_q == MAP_TILE_A) |->
        ({1'b0, req_col[A_TW_LG-1:0]} + (A_TW_LG+1)'(req_len) <= (A_TW_LG+1)'(1 << A_TW_LG)));

    // R7
    lin_chan_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_q == MAP_LINEAR) |->
        ({1'b0, req_col[CH_LG-1:0]} + (CH_LG+1)'(req_len) <= (CH_LG+1)'(1 << CH_LG)));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_row) && $stable(req_col)
        && $stable(req_len) && $stable(req_bank) && $stable(req_chan));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && cmd_ready);
endmodule

// File: tb/tile2d_burst_gen_tb.sv
module tile2d_burst_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [11:0] cmd_width = '0;
    logic [10:0] cmd_height = '0;
    logic [3:0]  cmd_stride_lg = 4'd11;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [0:0]  req_chan;
    logic [1:0]  req_bank;
    logic [21:0] req_row;
    logic [7:0]  req_col;
    logic [5:0]  req_len;
    logic        done;

    always #2.5 clk = ~clk;

    tile2d_burst_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_width(cmd_width), .cmd_height(cmd_height),
        .cmd_stride_lg(cmd_stride_lg), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_len(req_len), .done(done)
    );

    int          n_cmp = 0, n_bad = 0, cyc = 0;
    logic [38:0] exp_q[$];
    bit          pend = 0, exp_zero = 0, bp_mode = 0, stall_prev = 0, finished = 0;
    int          acc_cyc = 0, last_hs = 0;
    logic [38:0] prev_f;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // reference: builds the burst list from the mapping rules
    task automatic build(input int a0, input int w, input int h, input int slg);
        int p = 1 << slg;
        int win = a0 >>> 20;
        for (int r = 0; r < h; r++) begin
            int a = a0 + r * p;
            int rem = w;
            while (rem > 0) begin
                int ch, bk, rw, cl, room, ln, tw, th, off, x, y, rb;
                if (win == 1 || win == 2) begin
                    tw = (win == 1) ? 16 : 32;
                    th = (win == 1) ? 16 : 8;
                    rb = (win == 1) ? 'h400 : 'h800;
                    off = a & 'hFFFFF;
                    x = off % p; y = off / p;
                    cl = (y % th) * tw + x % tw;
                    bk = (x / tw) % 4;
                    rw = rb + (y / th) * (p / (tw * 4)) + x / (tw * 4);
                    ch = (x / 64) % 2;
                    room = (tw - x % tw < 64 - x % 64) ? tw - x % tw : 64 - x % 64;
                end else begin
                    cl = a % 256; bk = (a / 256) % 4; rw = a / 1024; ch = (a / 64) % 2;
                    room = 64 - a % 64;
                end
                ln = rem;
                if (ln > 32) ln = 32;
                if (ln > room) ln = room;
                exp_q.push_back({ch[0], bk[1:0], rw[21:0], cl[7:0], ln[5:0]});
                rem -= ln;
                a += ln;
            end
        end
    endtask

    task automatic run_cmd(input int a0, input int w, input int h, input int slg);
        build(a0, w, h, slg);
        exp_zero = (w == 0 || h == 0);
        pend = 1;
        @(posedge clk); #1;
        cmd_addr = a0; cmd_width = w[11:0]; cmd_height = h[10:0];
        cmd_stride_lg = slg[3:0]; cmd_valid = 1'b1;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        while (pend && !finished) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    always @(posedge clk) #1 req_ready = bp_mode ? lfsr[3] : 1'b1;

    // per-clock monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [38:0] got;
            got = {req_chan, req_bank, req_row, req_col, req_len};
            if (stall_prev)
                chk(req_valid && got == prev_f, "R8 hold under backpressure", {25'd0, req_valid, got}, {25'd0, 1'b1, prev_f});
            if (req_valid && req_ready) begin
                if (exp_q.size() == 0)
                    chk(0, "R2 extra burst", {25'd0, got}, 64'd0);
                else begin
                    logic [38:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R2 R3 R4 R5 R6 R7 burst fields", {25'd0, got}, {25'd0, e});
                end
                last_hs = cyc;
            end
            if (cmd_valid && cmd_ready) acc_cyc = cyc;
            stall_prev = req_valid && !req_ready;
            prev_f = got;
            if (done) begin
                if (!pend) chk(0, "R9 unexpected done", 64'd1, 64'd0);
                else begin
                    chk(exp_q.size() == 0, "R2 bursts missing at done", exp_q.size(), 64'd0);
                    chk(cyc == (exp_zero ? acc_cyc + 1 : last_hs + 1), "R9 done timing",
                        cyc, exp_zero ? acc_cyc + 1 : last_hs + 1);
                    exp_q.delete();
                    pend = 0;
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10 reset cmd_ready", cmd_ready, 64'd1);
        chk(req_valid == 1'b0, "R10 reset req_valid", req_valid, 64'd0);
        chk(done == 1'b0, "R10 reset done", done, 64'd0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 idle ready", cmd_ready, 64'd1);
        // R3 window A, crosses tile rows and tile columns
        run_cmd(32'h0010_0000 + 14 * 2048 + 8, 40, 4, 11);
        // R4 window B, other tile shape
        run_cmd(32'h0020_0000 + 6 * 2048 + 20, 70, 3, 11);
        // R5 R7 linear, channel splits and max length
        run_cmd(32'h0000_0030, 100, 2, 11);
        // R9 zero width and zero height
        run_cmd(32'h0010_0000, 0, 5, 11);
        run_cmd(32'h0000_4000, 16, 0, 11);
        // R3 R6 wider pitch, tile and channel edges together
        run_cmd(32'h0010_0000 + 30 * 4096 + 60, 9, 3, 12);
        // R5 single byte
        run_cmd(32'h0000_07FF, 1, 1, 11);
        // R8 backpressure on all windows
        bp_mode = 1;
        run_cmd(32'h0010_0000 + 3 * 2048 + 5, 50, 3, 11);
        run_cmd(32'h0020_0000 + 9 * 2048 + 100, 60, 2, 11);
        run_cmd(32'h0000_1F10, 200, 2, 11);
        bp_mode = 0;
        run_cmd(32'h0020_0000 + 7 * 1024, 33, 2, 10);
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 100000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired R9 actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule